// File: doc/BRIEF.md
# Serial Character Receiver with Break Detection

This block receives asynchronous serial characters. A one-cycle oversample enable runs at sixteen times the bit rate. On each falling edge of the idle-high line the block checks the start bit at mid-bit. It then assembles 5 to 8 data bits, least significant bit first, in a shift register, and checks an optional parity bit and the stop bit. For every finished character it sends one strobe downstream. The strobe carries the data byte and three status flags: parity error, framing error and line break.

A line held low for a whole character is reported as a break. The block delivers an all-zero character with the break flag set. It does not look for a new start bit until the line has been high for half a bit time.

A line that falls low partway through a character is handled in two steps. The corrupted character is delivered first, with its error flags. If the line then stays low for one more full character time, the break character follows.

The baud-rate generator, the receive buffer and any register access are outside this block.

Top module: `serial_rx_break`

## Requirements
- R1: While idle, a low line seen on an oversample tick starts a candidate start bit. The line is sampled again on the 8th tick after that. If it reads high, the candidate is dropped, no character is delivered, and the block returns to hunting.
- R2: Data bits are sampled every 16 ticks, least significant bit first. The length code `len_sel` selects the number of data bits: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Unused upper bits of `char_data` read 0.
- R3: `par_mode` selects the parity mode. Code 0 means no parity bit. Code 1 means even parity and code 2 means odd parity. Code 3 behaves like code 0. A parity bit that does not match the selected sense sets `char_perr`.
- R4: A stop bit sampled low sets `char_ferr`, unless R5 applies.
- R5: If every sample of a character is low (start, data, parity and stop), the block delivers data 0 with `char_brk` set and `char_perr` and `char_ferr` clear.
- R6: After a break has been delivered, the line must be high on 8 consecutive ticks before a new start bit is accepted. A shorter high pulse followed by more low line produces no character.
- R7: When a character ends with a low stop bit but not all of its samples were low, it is delivered with `char_ferr` set. If the line then stays low on every tick for one more full character time, a second character follows with data 0 and `char_brk` set.
- R8: If the line goes high before that second character time ends, only the damaged character is delivered.
- R9: `char_vld` is a single-cycle pulse. It comes in the clock cycle after an oversample tick. `char_data` and the three flags change only together with `char_vld`.
- R10: During and right after reset, `char_vld`, `char_data` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversample enable, 16 per bit time |
| rx_line | input | 1 | Asynchronous serial line, high when idle |
| par_mode | input | 2 | Parity selection (0 none, 1 even, 2 odd, 3 none) |
| len_sel | input | 2 | Data length code (5 + code bits) |
| char_vld | output | 1 | Character delivered this cycle |
| char_data | output | DATA_W | Received data, zero for a break |
| char_perr | output | 1 | Parity error of the delivered character |
| char_ferr | output | 1 | Framing error of the delivered character |
| char_brk | output | 1 | Delivered character is a break |

## Verification
The bench uses the default parameters: OS_RATE 16, DATA_W 8 and SYNC_STAGES 2. It asserts the tick every fourth clock, so one bit lasts 64 clocks. At this rate the two-stage synchronizer and the tick phase shift the sample point by only a few clocks from the bit centre. This lets the bench drive every length code and every parity code with exact expected values. Because the oversample count is 16, the half-bit rearm window is 8 ticks. A 3-tick high pulse therefore falls clearly short of it. Pulses of this size can also be placed inside a character, to cut a frame at a chosen data bit for the mid-character break cases.

// File: rtl/rxbrk_pkg.sv
package rxbrk_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRKW, S_REARM
  } rx_state_e;

  localparam logic [1:0] PAR_NONE = 2'd0;
  localparam logic [1:0] PAR_EVEN = 2'd1;
  localparam logic [1:0] PAR_ODD  = 2'd2;
endpackage

// File: rtl/rxbrk_sync.sv
module rxbrk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] ff_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) ff_q[g] <= 1'b1;
          else        ff_q[g] <= d_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) ff_q[g] <= 1'b1;
          else        ff_q[g] <= ff_q[g-1];
      end
    end
  endgenerate

  assign d_sync = ff_q[STAGES-1];
endmodule

// File: rtl/rxbrk_ctrl.sv
module rxbrk_ctrl
  import rxbrk_pkg::*;
#(
  parameter int OS_RATE = 16,
  parameter int DATA_W  = 8,
  localparam int IW     = $clog2(DATA_W + 3)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic          rx,
  input  logic [1:0]    par_mode,
  input  logic [1:0]    len_sel,
  input  logic          all_low,
  output logic          go_start,
  output logic          smp_bit,
  output logic [IW-1:0] bit_idx,
  output logic          smp_par,
  output logic          smp_stop,
  output logic          brk_done
);
  localparam int CW   = $clog2(OS_RATE);
  localparam int HALF = OS_RATE / 2;

  rx_state_e       st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [IW-1:0]   idx_q, idx_d;
  logic [IW-1:0]   nbits, frame_last;
  logic            par_en, cnt_end, half_end;

  assign par_en     = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD);
  assign nbits      = IW'(DATA_W - 3) + IW'(len_sel);
  assign frame_last = nbits + (par_en ? IW'(2) : IW'(1));
  assign cnt_end    = (cnt_q == CW'(OS_RATE - 1));
  assign half_end   = (cnt_q == CW'(HALF - 1));
  assign bit_idx    = idx_q;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    go_start = 1'b0;
    smp_bit  = 1'b0;
    smp_par  = 1'b0;
    smp_stop = 1'b0;
    brk_done = 1'b0;
    if (os_tick) begin
      unique case (st_q)
        S_IDLE: if (!rx) begin
          st_d  = S_START;
          cnt_d = '0;
        end
        S_START: if (half_end) begin
          cnt_d = '0;
          if (rx) st_d = S_IDLE;
          else begin
            st_d     = S_DATA;
            idx_d    = '0;
            go_start = 1'b1;
          end
        end else cnt_d = cnt_q + CW'(1);
        S_DATA: if (cnt_end) begin
          cnt_d   = '0;
          smp_bit = 1'b1;
          if (idx_q == nbits - IW'(1)) st_d = par_en ? S_PAR : S_STOP;
          else                         idx_d = idx_q + IW'(1);
        end else cnt_d = cnt_q + CW'(1);
        S_PAR: if (cnt_end) begin
          cnt_d   = '0;
          smp_par = 1'b1;
          st_d    = S_STOP;
        end else cnt_d = cnt_q + CW'(1);
        S_STOP: if (cnt_end) begin
          cnt_d    = '0;
          idx_d    = '0;
          smp_stop = 1'b1;
          if (rx)           st_d = S_IDLE;
          else if (all_low) st_d = S_REARM;
          else              st_d = S_BRKW;
        end else cnt_d = cnt_q + CW'(1);
        S_BRKW: if (rx) st_d = S_IDLE;
        else if (cnt_end) begin
          cnt_d = '0;
          if (idx_q == frame_last) begin
            brk_done = 1'b1;
            st_d     = S_REARM;
          end else idx_d = idx_q + IW'(1);
        end else cnt_d = cnt_q + CW'(1);
        S_REARM: if (!rx)     cnt_d = '0;
        else if (half_end)    st_d  = S_IDLE;
        else                  cnt_d = cnt_q + CW'(1);
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/rxbrk_dpath.sv
module rxbrk_dpath
  import rxbrk_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IW    = $clog2(DATA_W + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx,
  input  logic [1:0]        par_mode,
  input  logic              go_start,
  input  logic              smp_bit,
  input  logic [IW-1:0]     bit_idx,
  input  logic              smp_par,
  input  logic              smp_stop,
  input  logic              brk_done,
  output logic              all_low,
  output logic              char_vld,
  output logic [DATA_W-1:0] char_data,
  output logic              char_perr,
  output logic              char_ferr,
  output logic              char_brk
);
  logic [DATA_W-1:0] sh_q, sh_d, dat_q, dat_d;
  logic acc_q, acc_d, pe_q, pe_d, low_q, low_d;
  logic vld_d, perr_d, ferr_d, brk_d;
  logic perr_q, ferr_q, brk_q, vld_q;

  always_comb begin
    sh_d   = sh_q;
    acc_d  = acc_q;
    pe_d   = pe_q;
    low_d  = low_q;
    vld_d  = 1'b0;
    dat_d  = dat_q;
    perr_d = perr_q;
    ferr_d = ferr_q;
    brk_d  = brk_q;
    if (go_start) begin
      sh_d  = '0;
      acc_d = 1'b0;
      pe_d  = 1'b0;
      low_d = 1'b1;
    end
    if (smp_bit) begin
      for (int i = 0; i < DATA_W; i++)
        if (IW'(i) == bit_idx) sh_d[i] = rx;
      acc_d = acc_q ^ rx;
      if (rx) low_d = 1'b0;
    end
    if (smp_par) begin
      pe_d = (par_mode == PAR_ODD) ? ~(acc_q ^ rx) : (acc_q ^ rx);
      if (rx) low_d = 1'b0;
    end
    if (smp_stop) begin
      vld_d = 1'b1;
      if (!rx && low_q) begin
        dat_d = '0; perr_d = 1'b0; ferr_d = 1'b0; brk_d = 1'b1;
      end else begin
        dat_d = sh_q; perr_d = pe_q; ferr_d = ~rx; brk_d = 1'b0;
      end
    end
    if (brk_done) begin
      vld_d = 1'b1;
      dat_d = '0; perr_d = 1'b0; ferr_d = 1'b0; brk_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0; acc_q <= 1'b0; pe_q <= 1'b0; low_q <= 1'b0;
      vld_q <= 1'b0; dat_q <= '0; perr_q <= 1'b0; ferr_q <= 1'b0; brk_q <= 1'b0;
    end else begin
      sh_q <= sh_d; acc_q <= acc_d; pe_q <= pe_d; low_q <= low_d;
      vld_q <= vld_d; dat_q <= dat_d; perr_q <= perr_d; ferr_q <= ferr_d; brk_q <= brk_d;
    end
  end

  assign all_low   = low_q;
  assign char_vld  = vld_q;
  assign char_data = dat_q;
  assign char_perr = perr_q;
  assign char_ferr = ferr_q;
  assign char_brk  = brk_q;
endmodule

// File: rtl/serial_rx_break.sv
module serial_rx_break #(
  parameter int OS_RATE     = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_line,
  input  logic [1:0]        par_mode,
  input  logic [1:0]        len_sel,
  output logic              char_vld,
  output logic [DATA_W-1:0] char_data,
  output logic              char_perr,
  output logic              char_ferr,
  output logic              char_brk
);
  localparam int IW = $clog2(DATA_W + 3);

  logic          rx_s, all_low, go_start, smp_bit, smp_par, smp_stop, brk_done;
  logic [IW-1:0] bit_idx;

  rxbrk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(rx_line), .d_sync(rx_s)
  );

  rxbrk_ctrl #(.OS_RATE(OS_RATE), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx(rx_s),
    .par_mode(par_mode), .len_sel(len_sel), .all_low(all_low),
    .go_start(go_start), .smp_bit(smp_bit), .bit_idx(bit_idx),
    .smp_par(smp_par), .smp_stop(smp_stop), .brk_done(brk_done)
  );

  rxbrk_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .rx(rx_s), .par_mode(par_mode),
    .go_start(go_start), .smp_bit(smp_bit), .bit_idx(bit_idx),
    .smp_par(smp_par), .smp_stop(smp_stop), .brk_done(brk_done),
    .all_low(all_low), .char_vld(char_vld), .char_data(char_data),
    .char_perr(char_perr), .char_ferr(char_ferr), .char_brk(char_brk)
  );
endmodule

// File: rtl/serial_rx_break_chk.sv
module serial_rx_break_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              os_tick,
  input logic [1:0]        par_mode,
  input logic [1:0]        len_sel,
  input logic              char_vld,
  input logic [DATA_W-1:0] char_data,
  input logic              char_perr,
  input logic              char_ferr,
  input logic              char_brk
);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    char_vld |=> !char_vld);

  a_r9_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    char_vld |-> $past(os_tick));

  a_r9_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    !char_vld |-> ($stable(char_data) && $stable(char_perr) &&
                   $stable(char_ferr) && $stable(char_brk)));

  a_r5_brk_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (char_vld && char_brk) |-> (char_data == '0 && !char_perr && !char_ferr));

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    char_vld |-> ((char_data >> (DATA_W - 3 + int'(len_sel))) == '0));

  a_r3_no_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (char_vld && (par_mode == 2'd0 || par_mode == 2'd3)) |-> !char_perr);
endmodule

bind serial_rx_break serial_rx_break_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .par_mode(par_mode),
  .len_sel(len_sel), .char_vld(char_vld), .char_data(char_data),
  .char_perr(char_perr), .char_ferr(char_ferr), .char_brk(char_brk)
);

// File: tb/serial_rx_break_test.sv
module serial_rx_break_test;
  localparam int BITCLK = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick = 1'b0;
  logic rx_line = 1'b1;
  logic [1:0] par_mode = 2'd0;
  logic [1:0] len_sel = 2'd3;
  logic char_vld, char_perr, char_ferr, char_brk;
  logic [7:0] char_data;

  int checks = 0;
  int failures = 0;
  int ncap = 0;
  int dbl = 0;
  logic prev_vld = 1'b0;
  logic [7:0] cap_data [64];
  logic       cap_perr [64];
  logic       cap_ferr [64];
  logic       cap_brk  [64];

  // {len, par, data, bad_par, bad_stop, exp_data, exp_perr, exp_ferr}
  localparam logic [23:0] VEC [8] = '{
    {2'd3, 2'd0, 8'hA5, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
    {2'd3, 2'd1, 8'h3C, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0},
    {2'd3, 2'd2, 8'h3C, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b0},
    {2'd2, 2'd1, 8'h5A, 1'b1, 1'b0, 8'h5A, 1'b1, 1'b0},
    {2'd0, 2'd0, 8'hFF, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b0},
    {2'd1, 2'd2, 8'h2B, 1'b0, 1'b0, 8'h2B, 1'b0, 1'b0},
    {2'd3, 2'd0, 8'h81, 1'b0, 1'b1, 8'h81, 1'b0, 1'b1},
    {2'd3, 2'd3, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}
  };

  serial_rx_break uut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
    .par_mode(par_mode), .len_sel(len_sel), .char_vld(char_vld),
    .char_data(char_data), .char_perr(char_perr), .char_ferr(char_ferr),
    .char_brk(char_brk)
  );

  always #5 clk = ~clk;

  initial begin
    int t = 0;
    forever begin
      @(negedge clk);
      t++;
      os_tick = (t % 4 == 0);
    end
  end

  always @(negedge clk) begin
    if (rst_n && char_vld && ncap < 64) begin
      cap_data[ncap] = char_data;
      cap_perr[ncap] = char_perr;
      cap_ferr[ncap] = char_ferr;
      cap_brk[ncap]  = char_brk;
      ncap++;
    end
    if (rst_n && char_vld && prev_vld) dbl++;
    prev_vld = char_vld;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input int bits);
    repeat (bits * BITCLK) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] len, input logic [1:0] par, input logic [7:0] d,
                      input logic bad_par, input logic bad_stop);
    int n = 5 + int'(len);
    logic p = 1'b0;
    rx_line = 1'b0; hold(1);
    for (int i = 0; i < n; i++) begin
      rx_line = d[i]; p = p ^ d[i]; hold(1);
    end
    if (par == 2'd1 || par == 2'd2) begin
      if (par == 2'd2) p = ~p;
      rx_line = p ^ bad_par; hold(1);
    end
    rx_line = ~bad_stop; hold(1);
    rx_line = 1'b1; hold(2);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    repeat (10) @(negedge clk);
    check("R10 vld", char_vld, 0);
    check("R10 data", char_data, 0);
    check("R10 flags", {char_perr, char_ferr, char_brk}, 0);
    rst_n = 1'b1;
    hold(1);
    check("R10 vld after release", char_vld, 0);

    // table walk: R2 lengths, R3 parity, R4 framing
    for (int k = 0; k < 8; k++) begin
      base = ncap;
      len_sel  = VEC[k][23:22];
      par_mode = VEC[k][21:20];
      send(VEC[k][23:22], VEC[k][21:20], VEC[k][19:12], VEC[k][11], VEC[k][10]);
      check("R2 one char", ncap - base, 1);
      check("R2 data", cap_data[base], VEC[k][9:2]);
      check("R3 perr", cap_perr[base], VEC[k][1]);
      check("R4 ferr", cap_ferr[base], VEC[k][0]);
      check("R5 no brk", cap_brk[base], 0);
    end
    len_sel = 2'd3; par_mode = 2'd0;

    // R1: glitch shorter than half a bit
    base = ncap;
    rx_line = 1'b0; repeat (12) @(negedge clk);
    rx_line = 1'b1; hold(20);
    check("R1 glitch rejected", ncap - base, 0);

    // R5/R6: whole-character break, then short high pulse
    base = ncap;
    rx_line = 1'b0; hold(14);
    check("R5 one brk char", ncap - base, 1);
    check("R5 data", cap_data[base], 0);
    check("R5 brk", cap_brk[base], 1);
    check("R5 ferr clear", cap_ferr[base], 0);
    rx_line = 1'b1; repeat (12) @(negedge clk);
    rx_line = 1'b0; hold(14);
    check("R6 no char after short high", ncap - base, 1);
    rx_line = 1'b1; hold(2);
    send(2'd3, 2'd0, 8'h5A, 1'b0, 1'b0);
    check("R6 rearmed count", ncap - base, 2);
    check("R6 rearmed data", cap_data[base+1], 8'h5A);

    // R7: break beginning mid-character, lasting a further frame
    base = ncap;
    rx_line = 1'b0; hold(1);
    for (int i = 0; i < 4; i++) begin rx_line = 1'b1; hold(1); end
    rx_line = 1'b0; hold(20);
    rx_line = 1'b1; hold(2);
    check("R7 two chars", ncap - base, 2);
    check("R7 damaged data", cap_data[base], 8'h0F);
    check("R7 damaged ferr", cap_ferr[base], 1);
    check("R7 damaged no brk", cap_brk[base], 0);
    check("R7 second brk", cap_brk[base+1], 1);
    check("R7 second data", cap_data[base+1], 0);

    // R8: mid-character break that ends early
    base = ncap;
    rx_line = 1'b0; hold(1);
    for (int i = 0; i < 4; i++) begin rx_line = 1'b1; hold(1); end
    rx_line = 1'b0; hold(6);
    rx_line = 1'b1; hold(14);
    check("R8 only damaged", ncap - base, 1);
    check("R8 ferr", cap_ferr[base], 1);
    check("R8 no brk", cap_brk[base], 0);

    check("R9 single-cycle pulses", dbl, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule